// File: doc/BRIEF.md
# Preemptive External Bus Arbiter

This block decides which of four memory controllers owns a shared external memory pad interface. Each controller raises an active-high request when it needs the bus. The arbiter answers with a grant to one controller. It can also send an active-high backoff, which asks the owner to finish its transfer early and let go. When the bus is free, the grant goes to the requesting controller with the best programmable rank. The owner keeps the grant until it lowers its own request. The arbiter never takes the bus away by itself. If a better-ranked controller starts to request, the arbiter raises backoff to the owner and waits for it to release.

A low-power handshake lets the system quiesce the bus. While the system holds its quiesce request, no new grant is given and any owner is told to back off. The acknowledge rises once no grant is outstanding. An activity output tells the system whether any request is pending or the bus is still owned.

Top module: `ext_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle, and a `bo_o` bit is only high together with the matching `gnt_o` bit.
- R2: When no grant is held, quiesce is low and at least one request is high at a clock edge, `gnt_o` goes high after that edge for the requester with the lowest rank. Requester i's rank is `rank_i[2i+1:2i]`, and rank 0 is the highest priority.
- R3: While the owner keeps its request high, its grant stays high and no other grant rises.
- R4: While a requester ranked better than the owner requests, `bo_o` for the owner is high one cycle later. Once high, it stays high until the owner releases.
- R5: When the owner's request is low at a clock edge, its `gnt_o` and `bo_o` are both low after that edge.
- R6: The grant never moves straight from one requester to another. At least one cycle with `gnt_o` all zero lies between two owners.
- R7: While `lp_req_i` is high, no grant rises.
- R8: While `lp_req_i` is high, the owner of the bus gets `bo_o` one cycle later.
- R9: `lp_ack_o` is high one cycle after an edge at which `lp_req_i` is high and no grant remains after that edge. It is low otherwise, and it is never high together with a grant.
- R10: `active_o` is high exactly when any request input is high or a grant is held.
- R11: During and right after reset, `gnt_o`, `bo_o` and `lp_ack_o` are all zero.
- R12: A controller that drops its request after backoff and raises it again one cycle later is granted again once the bus is free and it is the best-ranked requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Bus request, one bit per controller |
| rank_i | input | 8 | Four 2-bit rank fields forming a permutation; lower rank wins |
| lp_req_i | input | 1 | System asks to quiesce the bus |
| gnt_o | output | 4 | Bus grant, one bit per controller |
| bo_o | output | 4 | Backoff to the current owner |
| lp_ack_o | output | 1 | Quiesce acknowledged, no grant outstanding |
| active_o | output | 1 | Any request pending or grant held |

## Verification
Random request toggling under random rank permutations tests the priority choice when several controllers race for a free bus. It also separates correct holding from wrongful switching while the owner keeps its request. Directed sequences cover the backoff cases: a better-ranked requester arrives during ownership, the owner releases, and then re-requests after a one-cycle gap. These separate backoff timing from grant timing and check the mandatory idle cycle between owners. Quiesce pulses at random points, both idle and during ownership, test that new grants are blocked, that the owner is told to back off, and that the acknowledge waits until the owner releases.

// File: rtl/eba_pkg.sv
package eba_pkg;
   typedef enum logic {
      ST_FREE  = 1'b0,
      ST_OWNED = 1'b1
   } eba_state_e;
endpackage

// File: rtl/eba_rank_pick.sv
module eba_rank_pick #(
   parameter int NUM_REQ = 4,
   parameter int RANK_W  = $clog2(NUM_REQ)
) (
   input  logic [NUM_REQ-1:0]        req,
   input  logic [NUM_REQ*RANK_W-1:0] rank,
   output logic                      any,
   output logic [RANK_W-1:0]         win_idx
);
   localparam int IDX_W = RANK_W;

   initial begin
      if (NUM_REQ < 2) $error("eba_rank_pick: NUM_REQ must be at least 2");
      if ((1 << RANK_W) < NUM_REQ) $error("eba_rank_pick: RANK_W too narrow");
   end

   logic [RANK_W-1:0] best_rank;

   always_comb begin
      any       = 1'b0;
      win_idx   = '0;
      best_rank = '1;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (req[i] && (!any || rank[i*RANK_W +: RANK_W] < best_rank)) begin
            any       = 1'b1;
            best_rank = rank[i*RANK_W +: RANK_W];
            win_idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/eba_preempt.sv
module eba_preempt #(
   parameter int NUM_REQ = 4,
   parameter int RANK_W  = $clog2(NUM_REQ)
) (
   input  logic [NUM_REQ-1:0]        req,
   input  logic [NUM_REQ*RANK_W-1:0] rank,
   input  logic [RANK_W-1:0]         own_idx,
   output logic                      better_pending
);
   logic [RANK_W-1:0]  own_rank;
   logic [NUM_REQ-1:0] beats;

   always_comb begin
      own_rank = '0;
      for (int i = 0; i < NUM_REQ; i++)
         if (own_idx == RANK_W'(i)) own_rank = rank[i*RANK_W +: RANK_W];
   end

   genvar g;
   generate
      for (g = 0; g < NUM_REQ; g++) begin : g_cmp
         assign beats[g] = req[g] && (rank[g*RANK_W +: RANK_W] < own_rank);
      end
   endgenerate

   assign better_pending = |beats;
endmodule

// File: rtl/eba_lp_ctrl.sv
module eba_lp_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic lp_req,
   input  logic owned_next,
   input  logic any_req,
   input  logic owned,
   output logic lp_ack,
   output logic active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_ack <= 1'b0;
      else        lp_ack <= lp_req && !owned_next;
   end

   assign active = any_req || owned;
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
   parameter int NUM_REQ = 4,
   parameter int RANK_W  = $clog2(NUM_REQ)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REQ-1:0]        req_i,
   input  logic [NUM_REQ*RANK_W-1:0] rank_i,
   input  logic                      lp_req_i,
   output logic [NUM_REQ-1:0]        gnt_o,
   output logic [NUM_REQ-1:0]        bo_o,
   output logic                      lp_ack_o,
   output logic                      active_o
);
   import eba_pkg::*;

   initial begin
      if (NUM_REQ < 2 || NUM_REQ > 16) $error("ext_bus_arbiter: NUM_REQ out of range");
      if ((1 << RANK_W) < NUM_REQ) $error("ext_bus_arbiter: RANK_W too narrow");
   end

   eba_state_e         state_q, state_d;
   logic [RANK_W-1:0]  own_q, own_d;
   logic [NUM_REQ-1:0] gnt_q, gnt_d, bo_q, bo_d;
   logic               pick_any, better;
   logic [RANK_W-1:0]  pick_idx;
   logic               owner_req;

   eba_rank_pick #(.NUM_REQ(NUM_REQ), .RANK_W(RANK_W)) u_pick (
      .req(req_i), .rank(rank_i), .any(pick_any), .win_idx(pick_idx)
   );

   eba_preempt #(.NUM_REQ(NUM_REQ), .RANK_W(RANK_W)) u_pre (
      .req(req_i), .rank(rank_i), .own_idx(own_q), .better_pending(better)
   );

   always_comb begin
      owner_req = 1'b0;
      for (int i = 0; i < NUM_REQ; i++)
         if (own_q == RANK_W'(i)) owner_req = req_i[i];
   end

   always_comb begin
      state_d = state_q;
      own_d   = own_q;
      gnt_d   = gnt_q;
      bo_d    = bo_q;
      unique case (state_q)
         ST_FREE: begin
            if (!lp_req_i && pick_any) begin
               state_d = ST_OWNED;
               own_d   = pick_idx;
               gnt_d   = NUM_REQ'(1) << pick_idx;
            end
         end
         ST_OWNED: begin
            if (!owner_req) begin
               state_d = ST_FREE;
               gnt_d   = '0;
               bo_d    = '0;
            end else if (lp_req_i || better) begin
               bo_d = gnt_q;
            end
         end
         default: state_d = ST_FREE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FREE;
         own_q   <= '0;
         gnt_q   <= '0;
         bo_q    <= '0;
      end else begin
         state_q <= state_d;
         own_q   <= own_d;
         gnt_q   <= gnt_d;
         bo_q    <= bo_d;
      end
   end

   eba_lp_ctrl u_lp (
      .clk(clk), .rst_n(rst_n), .lp_req(lp_req_i),
      .owned_next(state_d == ST_OWNED), .any_req(|req_i),
      .owned(state_q == ST_OWNED), .lp_ack(lp_ack_o), .active(active_o)
   );

   assign gnt_o = gnt_q;
   assign bo_o  = bo_q;

   // Checks
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o) && ((bo_o & ~gnt_o) == '0));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_o & req_i) != '0) |=> (gnt_o == $past(gnt_o)));

   p_nodirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0) |=> (gnt_o == '0) || (gnt_o == $past(gnt_o)));

   p_lp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_req_i && gnt_o == '0) |=> (gnt_o == '0));

   p_lp_bo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_req_i && ((gnt_o & req_i) != '0)) |=> (bo_o == gnt_o));

   p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ack_o |-> (gnt_o == '0));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REQ; gi++) begin : g_chk
         p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[gi] && !req_i[gi]) |=> (!gnt_o[gi] && !bo_o[gi]));
         p_bo_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bo_o[gi] && req_i[gi]) |=> bo_o[gi]);
      end
   endgenerate
endmodule

// File: tb/ext_bus_arbiter_tb.sv
module ext_bus_arbiter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic [7:0] rank = 8'b11_10_01_00;
   logic       lp = 1'b0;
   logic [3:0] gnt, bo;
   logic       ack, act;

   int checks = 0, fails = 0;
   bit done = 0;

   int         m_own = -1;
   logic [3:0] m_gnt = '0, m_bo = '0;
   logic       m_ack = 1'b0;

   always #2 clk = ~clk;

   ext_bus_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .rank_i(rank), .lp_req_i(lp),
      .gnt_o(gnt), .bo_o(bo), .lp_ack_o(ack), .active_o(act)
   );

   function automatic int rk(input logic [7:0] r, input int i);
      return int'(r[i*2 +: 2]);
   endfunction

   function automatic int best(input logic [3:0] q, input logic [7:0] r);
      int b = -1;
      for (int i = 0; i < 4; i++)
         if (q[i] && (b < 0 || rk(r, i) < rk(r, b))) b = i;
      return b;
   endfunction

   function automatic bit better_than(input logic [3:0] q, input logic [7:0] r, input int o);
      for (int i = 0; i < 4; i++)
         if (q[i] && rk(r, i) < rk(r, o)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] a, input logic [7:0] e);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, a, e, $time);
      end
   endtask

   // One clock: model step with inputs held over the past edge, then compare.
   task automatic cyc();
      logic [3:0] pg;
      bit was_free, lp_edge;
      @(negedge clk);
      pg = m_gnt; was_free = (m_own < 0); lp_edge = lp;
      if (m_own < 0) begin
         if (!lp && req != 0) begin
            m_own = best(req, rank);
            m_gnt = 4'b1 << m_own;
         end
      end else if (!req[m_own]) begin
         m_own = -1; m_gnt = '0; m_bo = '0;
      end else if (lp || better_than(req, rank, m_own)) begin
         m_bo[m_own] = 1'b1;
      end
      m_ack = lp && (m_own < 0);
      chk($onehot0(gnt), "R1 onehot", {4'b0, gnt}, {4'b0, m_gnt});
      if (was_free && lp_edge)
         chk(gnt == m_gnt, "R7 no grant in quiesce", {4'b0, gnt}, {4'b0, m_gnt});
      else if (was_free && m_gnt != 0)
         chk(gnt == m_gnt, "R2 priority grant", {4'b0, gnt}, {4'b0, m_gnt});
      else if (was_free)
         chk(gnt == m_gnt, "R6 idle gap", {4'b0, gnt}, {4'b0, m_gnt});
      else if (m_gnt == pg)
         chk(gnt == m_gnt, "R3 hold", {4'b0, gnt}, {4'b0, m_gnt});
      else
         chk(gnt == m_gnt && bo == 0, "R5 release", {gnt, bo}, {m_gnt, 4'b0});
      if (lp_edge)
         chk(bo == m_bo, "R8 quiesce backoff", {4'b0, bo}, {4'b0, m_bo});
      else
         chk(bo == m_bo, "R4 backoff", {4'b0, bo}, {4'b0, m_bo});
      chk(ack == m_ack, "R9 ack", {7'b0, ack}, {7'b0, m_ack});
      chk(act == ((req != 0) || m_own >= 0), "R10 active", {7'b0, act},
          {7'b0, (req != 0) || m_own >= 0});
   endtask

   task automatic new_rank();
      int p[4] = '{0, 1, 2, 3};
      for (int i = 3; i > 0; i--) begin
         int j = $urandom_range(i, 0);
         int t = p[i]; p[i] = p[j]; p[j] = t;
      end
      for (int i = 0; i < 4; i++) rank[i*2 +: 2] = 2'(p[i]);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      chk(gnt == 0 && bo == 0 && ack == 0, "R11 in reset", {gnt, bo}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk(gnt == 0 && bo == 0 && ack == 0, "R11 after reset", {gnt, bo}, 8'h00);

      // Directed: rank identity, req2 owns, req0 preempts
      rank = 8'b11_10_01_00;
      req = 4'b0100; cyc();
      cyc();
      req = 4'b0101; cyc();
      chk(bo == 4'b0100, "R4 directed backoff", {4'b0, bo}, 8'b0100);
      req = 4'b0001; cyc();
      chk(gnt == 0 && bo == 0, "R5 directed release", {gnt, bo}, 8'h00);
      cyc();
      chk(gnt == 4'b0001, "R6 directed next owner", {4'b0, gnt}, 8'b0001);
      req = 4'b0101; cyc();
      req = 4'b0100; cyc(); cyc(); cyc();
      chk(gnt == 4'b0100, "R12 re-request granted", {4'b0, gnt}, 8'b0100);
      // Directed quiesce during ownership
      lp = 1'b1; cyc();
      chk(bo == 4'b0100 && ack == 0, "R8 directed", {bo, 3'b0, ack}, 8'b0100_0000);
      req = 4'b0000; cyc(); cyc();
      chk(ack == 1 && gnt == 0, "R9 directed ack", {gnt, 3'b0, ack}, 8'b0000_0001);
      req = 4'b1010; cyc(); cyc();
      chk(gnt == 0, "R7 directed blocked", {4'b0, gnt}, 8'h00);
      lp = 1'b0; cyc(); cyc();
      chk(gnt == 4'b0010, "R2 directed winner", {4'b0, gnt}, 8'b0010);
      req = 4'b0000; cyc(); cyc();

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         for (int i = 0; i < 4; i++)
            if ($urandom_range(3, 0) == 0) req[i] = ~req[i];
         if ($urandom_range(40, 0) == 0) lp = ~lp;
         if ($urandom_range(60, 0) == 0) new_rank();
         cyc();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule